// File: doc/BRIEF.md
# Low-Power Mode State Controller

This block sequences a system between three power states: Run, Standby and Halt. Software enters a low-power state by reading one of two trigger addresses on a simple register bus. A shutdown-enable configuration bit must be 1 for such a read to count. Halt stops only the CPU clock and ends on any enabled interrupt.

Standby stops both the CPU clock and the system clock. A write to the clock-settings address also forces one pass through Standby, whatever the shutdown-enable bit holds, so that new clock settings are applied while the clocks are stopped. How long Standby lasts depends on the clock source. With the PLL in use, the controller waits for PLL lock. In PLL-bypass mode, it waits for a minimum off time counted on a slow tick, made by halving a synchronized 32.768 kHz input.

When memory refresh is enabled, the controller asks the memory controller to enter self-refresh and waits for its acknowledge before stopping the clocks. On exit it restarts the clocks one cycle before it withdraws that request. An enabled interrupt also ends Standby.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the block is in Run: `pwr_state` = 2'b00, `cpu_clk_en` = 1, `sys_clk_en` = 1 and `sr_req` = 0.
- R2: A read (`bus_rd` = 1) of address `ADDR_STBY` (default 12'h00C) in Run with `shdn_en` = 1 enters Standby (`pwr_state` = 2'b01). With `rfsh_en` = 0, both clock enables are 0 from the cycle after the read.
- R3: A read of address `ADDR_HALT` (default 12'h008) in Run with `shdn_en` = 1 enters Halt (`pwr_state` = 2'b10). In Halt `cpu_clk_en` = 0 and `sys_clk_en` stays 1.
- R4: A read of either trigger address while `shdn_en` = 0 changes no output.
- R5: In Halt, an enabled interrupt returns the block to Run on the next cycle. An interrupt is enabled when `irq_pend & irq_mask` is nonzero. A pending interrupt whose mask bit is 0 leaves Halt unchanged.
- R6: A write (`bus_wr` = 1) to address `ADDR_CLKSET` (default 12'h020) in Run enters Standby whatever the value of `shdn_en`.
- R7: With `pll_bypass` = 0, Standby is held, with the clocks stopped, until `pll_locked` is 1. The block then leaves Standby on the next cycle.
- R8: With `pll_bypass` = 1, Standby lasts until a second rising edge of the half-rate slow tick has been seen.
  - The tick toggles on every rising edge of `slow_clk` after a two-flop synchronizer.
  - The block leaves Standby in the cycle after the count reaches two.
  - This gives between one and two tick periods in Standby.
- R9: When Standby is entered with `rfsh_en` = 1:
  - `sr_req` rises the cycle after the trigger.
  - Both clocks stay enabled while `sr_ack` is 0.
  - Both clocks are gated the cycle after `sr_ack` is seen.
- R10: On leaving a Standby that raised `sr_req`, both clocks come back one cycle before `sr_req` returns to 0. `pwr_state` reads 2'b00 during that cycle.
- R11: An enabled interrupt ends Standby on the next cycle, in either PLL mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Register address of the access |
| shdn_en | input | 1 | Shutdown enable; gates the Standby and Halt trigger reads |
| rfsh_en | input | 1 | Memory refresh enabled; selects the self-refresh handshake |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_mask | input | NIRQ | Interrupt enable mask |
| pll_locked | input | 1 | PLL lock indication |
| pll_bypass | input | 1 | 1 when the PLL is bypassed and the external clock is used |
| slow_clk | input | 1 | Asynchronous 32.768 kHz clock |
| sr_ack | input | 1 | Self-refresh acknowledge from the memory controller |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| sys_clk_en | output | 1 | System clock gate enable |
| sr_req | output | 1 | Self-refresh request to the memory controller |
| pwr_state | output | 2 | 00 Run, 01 Standby, 10 Halt |

## Verification
The properties assume the following about the inputs:
- At most one of `bus_rd` and `bus_wr` is high in a cycle.
- `sr_ack` is raised only while `sr_req` is high, and stays high until the request falls.

The stimulus drives every bus access as a single-cycle strobe. Acknowledges come from a small responder that answers three cycles after the request and follows the request down. The PLL lock and interrupt inputs are changed only between sequences or while the block waits in a low-power state. The slow clock runs at a fixed ratio to the system clock, so the bypass timer sees both early and late tick phases.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_SRWAIT = 3'd1,
    PS_STBY   = 3'd2,
    PS_WAKE   = 3'd3,
    PS_HALT   = 3'd4
  } psc_state_e;

  // Externally visible power code: 00 run, 01 standby, 10 halt
  function automatic logic [1:0] state_code(psc_state_e s);
    case (s)
      PS_SRWAIT, PS_STBY: return 2'b01;
      PS_HALT:            return 2'b10;
      default:            return 2'b00;
    endcase
  endfunction

  function automatic logic cpu_on(psc_state_e s);
    return (s == PS_RUN) || (s == PS_SRWAIT) || (s == PS_WAKE);
  endfunction

  function automatic logic sys_on(psc_state_e s);
    return s != PS_STBY;
  endfunction

endpackage

// File: rtl/psc_bus_decode.sv
module psc_bus_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_STBY   = 12'h00C,
  parameter logic [ADDR_W-1:0] ADDR_HALT   = 12'h008,
  parameter logic [ADDR_W-1:0] ADDR_CLKSET = 12'h020
) (
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              shdn_en,
  output logic              stby_rd,
  output logic              halt_rd,
  output logic              clk_wr
);
  always_comb begin
    stby_rd = bus_rd && shdn_en && (bus_addr == ADDR_STBY);
    halt_rd = bus_rd && shdn_en && (bus_addr == ADDR_HALT);
    clk_wr  = bus_wr && (bus_addr == ADDR_CLKSET);
  end
endmodule

// File: rtl/psc_slow_timer.sv
module psc_slow_timer #(
  parameter int SYNC_STAGES = 2,
  parameter int OFF_TICKS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  input  logic run_en,
  output logic done
);
  localparam int CW = $clog2(OFF_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   div_q;
  logic [CW-1:0]          cnt_q;
  logic                   slow_rise;
  logic                   tick_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], slow_clk};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign slow_rise = sync_q[SYNC_STAGES-1] && !last_q;
  assign tick_rise = slow_rise && !div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      div_q <= div_q ^ slow_rise;
      if (!run_en)
        cnt_q <= '0;
      else if (tick_rise && (cnt_q < CW'(OFF_TICKS)))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q >= CW'(OFF_TICKS));
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_rd,
  input  logic       halt_rd,
  input  logic       clk_wr,
  input  logic       rfsh_en,
  input  logic       irq_any,
  input  logic       pll_bypass,
  input  logic       pll_locked,
  input  logic       timer_done,
  input  logic       sr_ack,
  output psc_state_e state,
  output logic       sr_req
);
  psc_state_e st_q, st_d;
  logic       sr_q;
  logic       reload_done;

  assign reload_done = pll_bypass ? timer_done : pll_locked;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PS_RUN: begin
        if (stby_rd || clk_wr) st_d = rfsh_en ? PS_SRWAIT : PS_STBY;
        else if (halt_rd)      st_d = PS_HALT;
      end
      PS_SRWAIT: if (sr_ack) st_d = PS_STBY;
      PS_STBY:   if (irq_any || reload_done) st_d = sr_q ? PS_WAKE : PS_RUN;
      PS_WAKE:   st_d = PS_RUN;
      PS_HALT:   if (irq_any) st_d = PS_RUN;
      default:   st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_RUN;
      sr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == PS_RUN && st_d == PS_SRWAIT) sr_q <= 1'b1;
      else if (st_q == PS_WAKE)                sr_q <= 1'b0;
    end
  end

  assign state  = st_q;
  assign sr_req = sr_q;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NIRQ        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OFF_TICKS   = 2,
  parameter logic [ADDR_W-1:0] ADDR_STBY   = 12'h00C,
  parameter logic [ADDR_W-1:0] ADDR_HALT   = 12'h008,
  parameter logic [ADDR_W-1:0] ADDR_CLKSET = 12'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              shdn_en,
  input  logic              rfsh_en,
  input  logic [NIRQ-1:0]   irq_pend,
  input  logic [NIRQ-1:0]   irq_mask,
  input  logic              pll_locked,
  input  logic              pll_bypass,
  input  logic              slow_clk,
  input  logic              sr_ack,
  output logic              cpu_clk_en,
  output logic              sys_clk_en,
  output logic              sr_req,
  output logic [1:0]        pwr_state
);
  logic       stby_rd, halt_rd, clk_wr;
  logic       irq_any;
  logic       timer_done;
  psc_state_e state;

  assign irq_any = |(irq_pend & irq_mask);

  psc_bus_decode #(
    .ADDR_W(ADDR_W), .ADDR_STBY(ADDR_STBY),
    .ADDR_HALT(ADDR_HALT), .ADDR_CLKSET(ADDR_CLKSET)
  ) u_dec (
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .shdn_en(shdn_en),
    .stby_rd(stby_rd), .halt_rd(halt_rd), .clk_wr(clk_wr)
  );

  psc_slow_timer #(.SYNC_STAGES(SYNC_STAGES), .OFF_TICKS(OFF_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .run_en(state == PS_STBY), .done(timer_done)
  );

  psc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stby_rd(stby_rd), .halt_rd(halt_rd),
    .clk_wr(clk_wr), .rfsh_en(rfsh_en), .irq_any(irq_any),
    .pll_bypass(pll_bypass), .pll_locked(pll_locked),
    .timer_done(timer_done), .sr_ack(sr_ack), .state(state), .sr_req(sr_req)
  );

  assign cpu_clk_en = cpu_on(state);
  assign sys_clk_en = sys_on(state);
  assign pwr_state  = state_code(state);
endmodule

// File: rtl/psc_checker.sv
module psc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stby_rd,
  input logic       rfsh_en,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       shdn_en,
  input logic       irq_any,
  input logic       pll_bypass,
  input logic       pll_locked,
  input logic       sr_ack,
  input logic       cpu_clk_en,
  input logic       sys_clk_en,
  input logic       sr_req,
  input logic [1:0] pwr_state
);
  AST_RESET_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwr_state == 2'b00 && cpu_clk_en && sys_clk_en && !sr_req)); // R1

  AST_STBY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_rd && !rfsh_en && pwr_state == 2'b00 && !sr_req) |=> (pwr_state == 2'b01 && !sys_clk_en && !cpu_clk_en)); // R2

  AST_HALT_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10) |-> (!cpu_clk_en && sys_clk_en)); // R3

  AST_NO_SHDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 && !sr_req && bus_rd && !bus_wr && !shdn_en) |=> (pwr_state == 2'b00 && cpu_clk_en && sys_clk_en)); // R4

  AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10 && irq_any) |=> (pwr_state == 2'b00 && cpu_clk_en)); // R5

  AST_PLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_clk_en && !pll_bypass && !pll_locked && !irq_any) |=> !sys_clk_en); // R7

  AST_SR_ACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sys_clk_en) && sr_req) |-> $past(sr_ack)); // R9

  AST_UNGATE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_req) |-> (sys_clk_en && $past(sys_clk_en) && cpu_clk_en)); // R10

  AST_IRQ_STBY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_clk_en && irq_any) |=> sys_clk_en); // R11

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11); // R1
endmodule

bind pwr_state_ctrl psc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stby_rd(stby_rd), .rfsh_en(rfsh_en),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .shdn_en(shdn_en), .irq_any(irq_any),
  .pll_bypass(pll_bypass), .pll_locked(pll_locked), .sr_ack(sr_ack),
  .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .sr_req(sr_req),
  .pwr_state(pwr_state)
);

// File: tb/sim_pwr_state_ctrl.sv
module sim_pwr_state_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        shdn_en = 1'b0, rfsh_en = 1'b0;
  logic [7:0]  irq_pend = '0, irq_mask = '0;
  logic        pll_locked = 1'b0, pll_bypass = 1'b1, slow_clk = 1'b0, sr_ack = 1'b0;
  logic        cpu_clk_en, sys_clk_en, sr_req;
  logic [1:0]  pwr_state;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done_flag = 0;

  always #5 clk = ~clk;

  pwr_state_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .shdn_en(shdn_en), .rfsh_en(rfsh_en), .irq_pend(irq_pend), .irq_mask(irq_mask),
    .pll_locked(pll_locked), .pll_bypass(pll_bypass), .slow_clk(slow_clk), .sr_ack(sr_ack),
    .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .sr_req(sr_req), .pwr_state(pwr_state)
  );

  // Reference model: 0 run, 1 waiting for ack, 2 standby, 3 waking, 4 halt
  int m_st = 0, m_cnt = 0, m_edges = 0;
  bit m_sr = 0;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sr = 0; m_cnt = 0; m_edges = 0; hist = '{0, 0, 0};
    end else begin
      bit rise, tick, irq, go_stby, halt_go;
      int nxt;
      rise    = hist[1] && !hist[2];
      tick    = rise && (m_edges % 2 == 0);
      irq     = (irq_pend & irq_mask) != 0;
      go_stby = (bus_rd && shdn_en && bus_addr == 12'h00C) || (bus_wr && bus_addr == 12'h020);
      halt_go = bus_rd && shdn_en && bus_addr == 12'h008;
      nxt = m_st;
      case (m_st)
        0: if (go_stby) nxt = rfsh_en ? 1 : 2; else if (halt_go) nxt = 4;
        1: if (sr_ack) nxt = 2;
        2: if (irq || (pll_bypass ? (m_cnt >= 2) : pll_locked)) nxt = m_sr ? 3 : 0;
        3: nxt = 0;
        default: if (irq) nxt = 0;
      endcase
      if (m_st == 0 && nxt == 1) m_sr = 1;
      else if (m_st == 3) m_sr = 0;
      if (m_st != 2) m_cnt = 0;
      else if (tick && m_cnt < 2) m_cnt++;
      if (rise) m_edges++;
      hist.push_front(slow_clk);
      void'(hist.pop_back());
      m_st = nxt;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison and acknowledge responder, away from the active edge
  int ack_wait = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] exp_v;
      exp_v = {(m_st == 1 || m_st == 2) ? 2'b01 : (m_st == 4 ? 2'b10 : 2'b00),
               (m_st == 0 || m_st == 1 || m_st == 3), (m_st != 2), m_sr};
      check(cur_req, "state/cpu/sys/sr", {27'd0, pwr_state, cpu_clk_en, sys_clk_en, sr_req},
            {27'd0, exp_v});
    end
    if (sr_req) ack_wait++; else ack_wait = 0;
    sr_ack = sr_req && ack_wait >= 3;
  end

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      slow_clk = ~slow_clk;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(bit wr, logic [11:0] a);
    @(negedge clk);
    bus_rd = !wr; bus_wr = wr; bus_addr = a;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic wait_run(string req, int max_c);
    int k = 0;
    while (!(pwr_state == 2'b00 && !sr_req) && k < max_c) begin
      @(negedge clk); k++;
    end
    check(req, "returned to run", {31'd0, pwr_state == 2'b00 && !sr_req}, 32'd1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    check("R1", "reset state", {28'd0, pwr_state, cpu_clk_en, sys_clk_en},
          {28'd0, 2'b00, 1'b1, 1'b1});
    check("R1", "reset sr_req", {31'd0, sr_req}, 32'd0);

    // R4: trigger reads ignored while shutdown disabled
    cur_req = "R4";
    access(0, 12'h00C);
    access(0, 12'h008);
    cyc(2);
    check("R4", "no change", {30'd0, pwr_state}, 32'd0);

    // R3 / R5: halt, masked interrupt ignored, then enabled interrupt wakes
    cur_req = "R3";
    shdn_en = 1;
    access(0, 12'h008);
    cyc(3);
    check("R3", "halt code", {30'd0, pwr_state}, 32'd2);
    check("R3", "cpu gated, sys on", {30'd0, cpu_clk_en, sys_clk_en}, 32'b01);
    cur_req = "R5";
    irq_pend = 8'h04; irq_mask = 8'h02;
    cyc(5);
    check("R5", "masked irq ignored", {30'd0, pwr_state}, 32'd2);
    irq_mask = 8'h06;
    cyc(2);
    check("R5", "enabled irq wakes", {30'd0, pwr_state}, 32'd0);
    irq_pend = 0; irq_mask = 0;

    // R2 / R8: bypass standby, minimum off time
    for (int rep = 0; rep < 3; rep++) begin
      cur_req = "R8";
      access(0, 12'h00C);
      check("R2", "standby gated", {29'd0, pwr_state, sys_clk_en}, {29'd0, 2'b01, 1'b0});
      cyc(rep * 5);
      wait_run("R8", 200);
      cyc(3);
    end

    // R6 / R7: clock-settings write with shutdown off, PLL mode waits for lock
    cur_req = "R7";
    shdn_en = 0; pll_bypass = 0; pll_locked = 0;
    access(1, 12'h020);
    check("R6", "clkset forces standby", {30'd0, pwr_state}, 32'd1);
    cyc(80);
    check("R7", "held without lock", {31'd0, sys_clk_en}, 32'd0);
    pll_locked = 1;
    wait_run("R7", 10);
    pll_locked = 0;
    cyc(3);

    // R9 / R10: self-refresh handshake, bypass exit
    cur_req = "R9";
    shdn_en = 1; rfsh_en = 1; pll_bypass = 1;
    access(0, 12'h00C);
    check("R9", "request with clocks on", {29'd0, sr_req, cpu_clk_en, sys_clk_en}, 32'b111);
    cyc(6);
    check("R9", "gated after ack", {30'd0, sr_req, sys_clk_en}, 32'b10);
    cur_req = "R10";
    wait_run("R10", 200);
    cyc(3);

    // R6 with refresh handshake, PLL lock exit
    cur_req = "R10";
    pll_bypass = 0;
    access(1, 12'h020);
    cyc(20);
    pll_locked = 1;
    wait_run("R10", 10);
    pll_locked = 0;
    cyc(3);

    // R11: interrupt ends standby in PLL mode and in bypass mode
    cur_req = "R11";
    rfsh_en = 0;
    access(0, 12'h00C);
    cyc(10);
    irq_pend = 8'h80; irq_mask = 8'h80;
    cyc(2);
    check("R11", "irq ends standby (pll)", {30'd0, pwr_state}, 32'd0);
    irq_pend = 0;
    pll_bypass = 1;
    access(0, 12'h00C);
    cyc(2);
    irq_pend = 8'h80;
    cyc(2);
    check("R11", "irq ends standby (bypass)", {30'd0, pwr_state}, 32'd0);
    irq_pend = 0; irq_mask = 0;
    cyc(5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule